// File: doc/BRIEF.md
# Split 64-bit Register Debug Access

The block gives a debug controller access to a bank of eight 64-bit data registers over a channel that carries only 32-bit words. Each register is reached as two longwords, picked by a half-select bit. A read of either half returns that half and changes nothing. A write goes through a 64-bit staging operand in two steps. The upper-half write fills only the staging high word. The lower-half write supplies the low word and commits all 64 bits to the register named by that lower write, in the same cycle.

A sequencer state machine tracks whether an upper half is waiting. Its states are SEQ_EMPTY and SEQ_HALF. The transition "stage" goes from SEQ_EMPTY to SEQ_HALF on an upper write, and "restage" keeps SEQ_HALF on a further upper write. The transition "commit" goes from SEQ_HALF to SEQ_EMPTY on a lower write. The transition "orphan commit" keeps SEQ_EMPTY on a lower write with nothing waiting; that write still commits, using the stale staging high word, and it raises a sequence-error flag. A second state machine holds the unit state, with the states UNIT_NULL and UNIT_IDLE. Its transition "wake" goes from UNIT_NULL to UNIT_IDLE on any write, and UNIT_IDLE is held until reset.

Each request is taken in one cycle and answered by a one-cycle acknowledge on the next cycle.

Top module: `split64_dbg_access`

## Requirements
- R1: After reset, every register half reads 0, the staging operand is 0, nothing is pending, `unit_idle` is 0 (NULL), and `rsp_ack`, `rsp_seq_err` and `rsp_rdata` are 0.
- R2: A request sampled at a rising clock edge with `req_valid` high produces `rsp_ack` high for exactly the following cycle. When no request is taken, `rsp_ack` is 0 in the next cycle.
- R3: A read (`req_write`=0) with `req_upper`=1 returns bits 63:32 of register `req_index` on `rsp_rdata` during its acknowledge cycle. With `req_upper`=0 it returns bits 31:0. The two halves may be read in either order.
- R4: A read changes no register, does not change the pending upper half, and does not change `unit_idle`.
- R5: An upper write (`req_write`=1, `req_upper`=1) loads `req_wdata` into the staging high word only. The addressed register keeps its old value.
- R6: A lower write (`req_write`=1, `req_upper`=0) that follows an upper write writes {staging high, `req_wdata`} into register `req_index` of the lower write. `rsp_seq_err` stays 0.
- R7: A lower write with no pending upper write still commits {staging high, `req_wdata`}. Here the staging high word is the last upper data written, or 0 since reset. `rsp_seq_err` is 1 in its acknowledge cycle, and only then.
- R8: Any write sets `unit_idle` to 1 (IDLE) from its acknowledge cycle onward. It stays 1 until reset, and reads never set it.
- R9: A second upper write before a lower write replaces the staging high word, raises no sequence error, and leaves the upper half pending.
- R10: During the acknowledge of a write, `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 3 | Register number |
| req_upper | input | 1 | 1 = upper longword (63:32), 0 = lower longword (31:0) |
| req_wdata | input | 32 | Write data |
| rsp_ack | output | 1 | One-cycle acknowledge, one cycle after the request |
| rsp_rdata | output | 32 | Read data, valid while `rsp_ack` is high |
| rsp_seq_err | output | 1 | Lower write committed with no pending upper half |
| unit_idle | output | 1 | Unit state: 0 = NULL, 1 = IDLE |

## Verification
Three events can fall in one cycle: a lower-write commit, the raising of a sequence error, and the wake of the unit state. They all coincide when the first write after reset is an orphan lower write. The bench provokes this directly after reset. It then reads both halves back and expects a zero high word, an error flag in the acknowledge cycle, and `unit_idle` going high in that same cycle. Random mixes of reads, orphan lower writes and repeated upper writes test the pairing of stage and commit against a bench model of the staging word and the pending flag.

// File: rtl/split64_pkg.sv
package split64_pkg;

    typedef enum logic {
        SEQ_EMPTY = 1'b0,
        SEQ_HALF  = 1'b1
    } seq_state_e;

    typedef enum logic {
        UNIT_NULL = 1'b0,
        UNIT_IDLE = 1'b1
    } unit_state_e;

endpackage

// File: rtl/split64_stager.sv
module split64_stager
    import split64_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                up_wr,
    input  logic                lo_wr,
    input  logic [HALF_W-1:0]   wdata,
    output logic                commit,
    output logic [2*HALF_W-1:0] commit_data,
    output logic                orphan,
    output logic                pending
);

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic [HALF_W-1:0] stage_hi_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: stage, restage, commit, orphan commit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_EMPTY: if (up_wr) state_d = SEQ_HALF;
            SEQ_HALF:  if (lo_wr) state_d = SEQ_EMPTY;
            default:   state_d = SEQ_EMPTY;
        endcase
    end

    // staging high word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_hi_q <= '0;
        end else if (up_wr) begin
            stage_hi_q <= wdata;
        end
    end

    // outputs
    always_comb begin
        commit      = lo_wr;
        commit_data = {stage_hi_q, wdata};
        orphan      = 1'b0;
        pending     = 1'b0;
        unique case (state_q)
            SEQ_EMPTY: orphan  = lo_wr;
            SEQ_HALF:  pending = 1'b1;
            default:   orphan  = 1'b0;
        endcase
    end

    assert_stage_pends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        up_wr |=> pending);

    assert_commit_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> !pending);

    assert_restage_no_orphan_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !lo_wr) |=> !orphan || pending);

endmodule

// File: rtl/split64_bank.sv
module split64_bank #(
    parameter int IDX_W  = 3,
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [IDX_W-1:0]    commit_idx,
    input  logic [2*HALF_W-1:0] commit_data,
    input  logic                rd_en,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic                rd_upper,
    output logic [HALF_W-1:0]   rdata
);

    localparam int NUM_REGS = 1 << IDX_W;
    localparam int DATA_W   = 2 * HALF_W;

    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic [DATA_W-1:0]               rd_word;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (commit && (commit_idx == IDX_W'(i))) begin
                regs[i] <= commit_data;
            end
        end
    end

    assign rd_word = regs[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_upper ? rd_word[DATA_W-1:HALF_W] : rd_word[HALF_W-1:0];
        end else begin
            rdata <= '0;
        end
    end

    assert_read_keeps_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !commit) |=> $stable(regs));

endmodule

// File: rtl/split64_unit_flag.sv
module split64_unit_flag
    import split64_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_wr,
    output logic unit_idle
);

    unit_state_e state_q;
    unit_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= UNIT_NULL;
        end else begin
            state_q <= state_d;
        end
    end

    // transition: wake
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UNIT_NULL: if (any_wr) state_d = UNIT_IDLE;
            UNIT_IDLE: state_d = UNIT_IDLE;
            default:   state_d = UNIT_NULL;
        endcase
    end

    always_comb begin
        unique case (state_q)
            UNIT_IDLE: unit_idle = 1'b1;
            default:   unit_idle = 1'b0;
        endcase
    end

    assert_idle_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unit_idle |=> unit_idle);

    assert_write_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr |=> unit_idle);

endmodule

// File: rtl/split64_dbg_access.sv
module split64_dbg_access #(
    parameter int IDX_W  = 3,
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_index,
    input  logic              req_upper,
    input  logic [HALF_W-1:0] req_wdata,
    output logic              rsp_ack,
    output logic [HALF_W-1:0] rsp_rdata,
    output logic              rsp_seq_err,
    output logic              unit_idle
);

    localparam int DATA_W = 2 * HALF_W;

    logic              up_wr;
    logic              lo_wr;
    logic              rd_en;
    logic              commit;
    logic [DATA_W-1:0] commit_data;
    logic              orphan;
    logic              pending;

    assign up_wr = req_valid &&  req_write &&  req_upper;
    assign lo_wr = req_valid &&  req_write && !req_upper;
    assign rd_en = req_valid && !req_write;

    split64_stager #(.HALF_W(HALF_W)) u_stager (
        .clk         (clk),
        .rst_n       (rst_n),
        .up_wr       (up_wr),
        .lo_wr       (lo_wr),
        .wdata       (req_wdata),
        .commit      (commit),
        .commit_data (commit_data),
        .orphan      (orphan),
        .pending     (pending)
    );

    split64_bank #(.IDX_W(IDX_W), .HALF_W(HALF_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_idx  (req_index),
        .commit_data (commit_data),
        .rd_en       (rd_en),
        .rd_idx      (req_index),
        .rd_upper    (req_upper),
        .rdata       (rsp_rdata)
    );

    split64_unit_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_wr    (up_wr || lo_wr),
        .unit_idle (unit_idle)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_ack     <= 1'b0;
            rsp_seq_err <= 1'b0;
        end else begin
            rsp_ack     <= req_valid;
            rsp_seq_err <= orphan;
        end
    end

    assert_err_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_seq_err |-> rsp_ack);

    assert_read_keeps_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> $stable(pending));

    assert_write_rdata_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));

endmodule

// File: tb/tb_split64_dbg_access.sv
module tb_split64_dbg_access;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_index = '0;
    logic        req_upper = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_ack;
    logic [31:0] rsp_rdata;
    logic        rsp_seq_err;
    logic        unit_idle;

    int n_checks = 0;
    int n_fails  = 0;

    logic [63:0] m_regs [8];
    logic [31:0] m_stage;
    logic        m_pend;
    logic        m_idle;

    split64_dbg_access dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_index(req_index), .req_upper(req_upper), .req_wdata(req_wdata),
        .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .rsp_seq_err(rsp_seq_err),
        .unit_idle(unit_idle)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_half(int idx, logic up);
        return up ? m_regs[idx][63:32] : m_regs[idx][31:0];
    endfunction

    // one request; outputs sampled at the negedge after the capturing edge
    task automatic do_req(logic wr, int idx, logic up, logic [31:0] d);
        logic exp_err;
        logic [31:0] exp_rd;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_index = 3'(idx);
        req_upper = up;   req_wdata = d;
        exp_err = 1'b0;
        exp_rd  = '0;
        if (!wr) begin
            exp_rd = exp_half(idx, up);
        end else if (up) begin
            m_stage = d; m_pend = 1'b1; m_idle = 1'b1;
        end else begin
            exp_err = !m_pend;
            m_regs[idx] = {m_stage, d}; m_pend = 1'b0; m_idle = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 ack", 64'(rsp_ack), 64'd1);
        chk(wr ? "R10 rdata on write" : "R3 read half", 64'(rsp_rdata), 64'(exp_rd));
        chk(exp_err ? "R7 seq_err" : "R6 no seq_err", 64'(rsp_seq_err), 64'(exp_err));
        chk("R8 unit_idle", 64'(unit_idle), 64'(m_idle));
    endtask

    task automatic read_back(int idx);
        do_req(1'b0, idx, 1'b1, 32'h0);
        do_req(1'b0, idx, 1'b0, 32'h0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 8; i++) m_regs[i] = '0;
        m_stage = '0; m_pend = 1'b0; m_idle = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ack", 64'(rsp_ack), 64'd0);
        chk("R1 seq_err", 64'(rsp_seq_err), 64'd0);
        chk("R1 unit_idle", 64'(unit_idle), 64'd0);
        chk("R1 rdata", 64'(rsp_rdata), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 8; i++) read_back(i);   // R1 R3 R4: zeros, still NULL
        @(negedge clk);
        chk("R2 ack idle", 64'(rsp_ack), 64'd0);
        chk("R4 R8 reads keep NULL", 64'(unit_idle), 64'd0);

        // orphan lower write first: commit, error and wake in one cycle (R7 R8)
        do_req(1'b1, 3, 1'b0, 32'hA5A5_0003);
        read_back(3);
        // R5 upper write stages only; R6 commit
        do_req(1'b1, 5, 1'b1, 32'h1111_5555);
        read_back(5);
        do_req(1'b1, 5, 1'b0, 32'h2222_5555);
        read_back(5);
        // R9 restage
        do_req(1'b1, 1, 1'b1, 32'hDEAD_0001);
        do_req(1'b1, 1, 1'b1, 32'hBEEF_0002);
        do_req(1'b1, 6, 1'b0, 32'hCAFE_0006);
        read_back(6);
        read_back(1);
        // R7 stale staging after commit
        do_req(1'b1, 2, 1'b0, 32'h0000_0F02);
        read_back(2);
        // R4 read while pending keeps pending
        do_req(1'b1, 7, 1'b1, 32'h7777_0000);
        read_back(7);
        do_req(1'b1, 7, 1'b0, 32'h0000_7777);
        read_back(7);

        for (int n = 0; n < 400; n++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel < 4)      do_req(1'b0, int'($urandom_range(0, 7)), 1'($urandom), 32'h0);
            else if (sel < 7) do_req(1'b1, int'($urandom_range(0, 7)), 1'b1, $urandom);
            else              do_req(1'b1, int'($urandom_range(0, 7)), 1'b0, $urandom);
        end
        for (int i = 0; i < 8; i++) read_back(i);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule